// File: doc/BRIEF.md
# Page-Level Single-Error-Correcting ECC Engine

This block watches the data cycles on a NAND flash data bus and builds a Hamming-style check code that covers one whole page in a single step. Each one bit in the page contributes its position index, made of the word address and the bit offset, to a 16-bit parity accumulator. It also contributes the complement of that index to a 16-bit inverse-parity accumulator. On a write pass, software reads both accumulators after the last data word and stores the pair as a 4-byte code in the spare area.

On a read pass the page data is followed on the bus by the stored code. When the last code word arrives, the engine forms the syndrome and sorts it into one of four classes: no error, a single-bit data error with its location, a single-bit error inside the code, or an uncorrectable multiple error. A page that is fully erased, with all data and code bits at one, gives an all-ones location that software can recognise. Correcting the data buffer and sequencing the flash commands are outside this block.

The engine has a small register port. Software uses it to select the page size and the bus width, to restart the accumulation, and to read the status flags and the two 16-bit result registers.

Top module: `ecc_page_engine`

## Requirements
- R1: The page length is selected by mode bits [1:0]: 0, 1, 2 and 3 select data pages of 512, 1024, 2048 and 4096 bytes. The code words are accepted on the data cycles that follow the last data word.
- R2: Only cycles with `bus_valid` high are counted or accumulated. Cycles with `bus_valid` low have no effect on the results, whatever `bus_data` carries.
- R3: Once the last data word has been taken, register 3 holds the XOR of the index {word, bit} of every one bit in the page, and register 4 holds the XOR of the complements of those indices. The stored code is presented in this order: register 3 low byte, register 3 high byte, register 4 low byte, register 4 high byte. On a 16-bit bus it is sent as two halfwords instead: register 3, then register 4.
- R4: If the stored code matches the page, every error flag in status register 2 is clear ([0] any error, [1] code error, [2] multiple error) and registers 3 and 4 read zero.
- R5: If exactly one data bit is flipped, status reads any-error only. Register 3 then holds the bit offset in bits [3:0] and the word address in bits [15:4], and register 4 holds the complement of register 3.
- R6: If exactly one bit of the stored code is flipped, status [0] and [1] are set, and registers {4,3} hold a value with only that code bit set.
- R7: Any other nonzero syndrome sets status [0] and [2]. An erased page, with all data and code bits at one, reports 0xFFFF in registers 3 and 4.
- R8: Writing 1 to bit 0 of control register 0 clears both accumulators, the word count, the code capture and all status flags.
- R9: Status bit [3] (done) rises on the cycle after the last code word is accepted, and not before. Further data cycles change nothing until the next clear.
- R10: If mode bit [4] is 1, the bus is 16 bits wide: word addresses count halfwords and bit offsets run from 0 to 15. If it is 0, only bus bits [7:0] are used, addresses count bytes and offsets run from 0 to 7.
- R11: After reset the mode register, the status register and result registers 3 and 4 all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Marks a data cycle on the flash bus |
| bus_data | input | 16 | Flash bus data (only [7:0] is used in 8-bit mode) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 mode, 2 status, 3 parity, 4 inverse parity |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |

## Verification
A wrong word count or a wrong page-length decode does not stay hidden. It either moves the accumulator values that can be read before the code is sent, or it makes the first code word be taken as data, which turns a clean page into a multiple-error report on the next cycle. A bad contribution from a single bit position shows up only when that position carries a one, or is flipped. For this reason every bit offset is swept at the first, middle and last words of the smallest page for both bus widths, and every one of the 32 code bits is flipped in turn. A fault in the done timing or the hold logic shows up at the status register within one cycle of the last code word, or after extra data cycles sent once the check is complete.

// File: rtl/ecc_pkg.sv
// Package: shared widths, phase and class encodings, and register offsets
// for the page ECC engine. Assumes a bus of 2**BIT_W bits.
package ecc_pkg;
    localparam int ECC_WADDR_W = 12;
    localparam int ECC_BIT_W   = 4;

    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_CODE = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_DATA  = 2'd1,
        CL_CODE  = 2'd2,
        CL_MULTI = 2'd3
    } class_t;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_MODE = 3'd1;
    localparam logic [2:0] RA_STAT = 3'd2;
    localparam logic [2:0] RA_PAR  = 3'd3;
    localparam logic [2:0] RA_INV  = 3'd4;
endpackage

// File: rtl/ecc_word_parity.sv
// Module: ecc_word_parity
// Purpose: computes, for one bus word, the XOR of the position indices
//   {word_addr, bit} of all set bits, and the XOR of their complements.
// Assumes: BUS_W == 2**BIT_W; in narrow mode the upper half of the bus is
//   ignored, so bit offsets stay below BUS_W/2.
module ecc_word_parity #(
    parameter int WADDR_W = 12,
    parameter int BIT_W   = 4,
    localparam int BUS_W  = 1 << BIT_W,
    localparam int IDX_W  = WADDR_W + BIT_W
) (
    input  logic [WADDR_W-1:0] word_addr,
    input  logic [BUS_W-1:0]   data,
    input  logic               wide,
    output logic [IDX_W-1:0]   p_contrib,
    output logic [IDX_W-1:0]   n_contrib
);
    localparam int HALF = BUS_W / 2;

    logic [BUS_W-1:0] dm;
    logic             odd;
    logic [BIT_W-1:0] lo;

    // Mask off the unused half of the bus in 8-bit mode.
    assign dm  = wide ? data : {{HALF{1'b0}}, data[HALF-1:0]};
    assign odd = ^dm;

    // Low index bits: parity of the set bits whose offset has that bit set.
    always_comb begin
        for (int i = 0; i < BIT_W; i++) begin
            lo[i] = 1'b0;
            for (int b = 0; b < BUS_W; b++) begin
                if (b[i]) lo[i] = lo[i] ^ dm[b];
            end
        end
    end

    // High index bits repeat the word address once per set bit: odd count keeps it.
    assign p_contrib = {word_addr & {WADDR_W{odd}}, lo};
    assign n_contrib = p_contrib ^ {IDX_W{odd}};
endmodule

// File: rtl/ecc_page_seq.sv
// Module: ecc_page_seq
// Purpose: counts data words up to the selected page length, then the code
//   words, then holds in the done phase until a clear.
// Assumes: the mode does not change in the middle of a page.
module ecc_page_seq
    import ecc_pkg::*;
#(
    parameter int WADDR_W    = 12,
    parameter int BASE_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               dvalid,
    input  logic               wide,
    input  logic [1:0]         size,
    output phase_t             phase,
    output logic [WADDR_W-1:0] word_idx,
    output logic [1:0]         code_idx,
    output logic               data_step,
    output logic               code_step,
    output logic               code_last
);
    logic [WADDR_W:0]   span;
    logic [WADDR_W:0]   span_m1;
    logic [WADDR_W-1:0] last_word;
    logic [1:0]         last_code;

    // Number of bus words in the data page for this size and width.
    assign span      = ((WADDR_W+1)'(BASE_BYTES) << size) >> wide;
    assign span_m1   = span - (WADDR_W+1)'(1);
    assign last_word = span_m1[WADDR_W-1:0];
    assign last_code = wide ? 2'd1 : 2'd3;

    assign data_step = (phase == PH_DATA) && dvalid;
    assign code_step = (phase == PH_CODE) && dvalid;
    assign code_last = code_step && (code_idx == last_code);

    // Phase and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase    <= PH_DATA;
            word_idx <= '0;
            code_idx <= '0;
        end else begin
            case (phase)
                PH_DATA: if (dvalid) begin
                    if (word_idx == last_word) phase <= PH_CODE;
                    else word_idx <= word_idx + WADDR_W'(1);
                end
                PH_CODE: if (dvalid) begin
                    if (code_idx == last_code) phase <= PH_DONE;
                    else code_idx <= code_idx + 2'd1;
                end
                default: phase <= PH_DONE;
            endcase
        end
    end

    // R1: the data cycle carrying the last word moves the engine to code capture.
    p_enter_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && word_idx == last_word && !clr) |=> (phase == PH_CODE));

    // R9: the done phase is left only through a clear.
    p_stay_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && !clr) |=> (phase == PH_DONE));
endmodule

// File: rtl/ecc_syndrome_class.sv
// Module: ecc_syndrome_class
// Purpose: sorts a parity/inverse-parity syndrome into none, data error,
//   code error or multiple error.
// Assumes: the syndrome is the XOR of the computed and stored codes.
module ecc_syndrome_class
    import ecc_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] syn_p,
    input  logic [IDX_W-1:0] syn_n,
    output class_t           cls
);
    localparam int SYN_W = 2 * IDX_W;

    logic [SYN_W-1:0] syn;
    assign syn = {syn_n, syn_p};

    // Priority: zero, single set bit, complementary halves, anything else.
    always_comb begin
        if (syn == '0)                            cls = CL_NONE;
        else if ((syn & (syn - SYN_W'(1))) == '0) cls = CL_CODE;
        else if (syn_p == ~syn_n)                 cls = CL_DATA;
        else                                      cls = CL_MULTI;
    end
endmodule

// File: rtl/ecc_page_engine.sv
// Module: ecc_page_engine (top)
// Purpose: accumulates the page code over the data cycles, captures the
//   stored code that follows, classifies the syndrome and exposes the results
//   through a small register port.
// Assumes: software clears the engine after programming the mode and before
//   the first data cycle of a page; command and address cycles are presented
//   with bus_valid low.
module ecc_page_engine
    import ecc_pkg::*;
#(
    parameter int WADDR_W    = ECC_WADDR_W,
    parameter int BIT_W      = ECC_BIT_W,
    parameter int BASE_BYTES = 512,
    localparam int BUS_W     = 1 << BIT_W,
    localparam int IDX_W     = WADDR_W + BIT_W,
    localparam int REG_W     = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic [BUS_W-1:0] bus_data,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    localparam int HALF   = BUS_W / 2;
    localparam int CODE_W = 2 * IDX_W;

    logic [1:0]         mode_size;
    logic               mode_wide;
    logic [IDX_W-1:0]   par_q, inv_q;
    logic [CODE_W-1:0]  code_q, code_nx;
    logic               err_any, err_code, err_multi, done;
    logic               clr, unused_wdata;
    phase_t             phase;
    logic [WADDR_W-1:0] word_idx;
    logic [1:0]         code_idx;
    logic               data_step, code_step, code_last;
    logic [IDX_W-1:0]   p_contrib, n_contrib, syn_p, syn_n;
    class_t             cls;

    assign clr          = reg_we && (reg_addr == RA_CTRL) && reg_wdata[0];
    assign unused_wdata = ^{reg_wdata[REG_W-1:5], reg_wdata[3:2]};

    ecc_page_seq #(.WADDR_W(WADDR_W), .BASE_BYTES(BASE_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .dvalid(bus_valid),
        .wide(mode_wide), .size(mode_size), .phase(phase),
        .word_idx(word_idx), .code_idx(code_idx), .data_step(data_step),
        .code_step(code_step), .code_last(code_last)
    );

    ecc_word_parity #(.WADDR_W(WADDR_W), .BIT_W(BIT_W)) u_par (
        .word_addr(word_idx), .data(bus_data), .wide(mode_wide),
        .p_contrib(p_contrib), .n_contrib(n_contrib)
    );

    // Merge the incoming code word into the captured code.
    always_comb begin
        code_nx = code_q;
        if (mode_wide) begin
            if (code_idx[0]) code_nx[CODE_W-1:IDX_W] = bus_data;
            else             code_nx[IDX_W-1:0]      = bus_data;
        end else begin
            case (code_idx)
                2'd0:    code_nx[0*HALF +: HALF] = bus_data[HALF-1:0];
                2'd1:    code_nx[1*HALF +: HALF] = bus_data[HALF-1:0];
                2'd2:    code_nx[2*HALF +: HALF] = bus_data[HALF-1:0];
                default: code_nx[3*HALF +: HALF] = bus_data[HALF-1:0];
            endcase
        end
    end

    assign syn_p = par_q ^ code_nx[IDX_W-1:0];
    assign syn_n = inv_q ^ code_nx[CODE_W-1:IDX_W];

    ecc_syndrome_class #(.IDX_W(IDX_W)) u_cls (
        .syn_p(syn_p), .syn_n(syn_n), .cls(cls)
    );

    // Mode register: page size and bus width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_size <= 2'd0;
            mode_wide <= 1'b0;
        end else if (reg_we && reg_addr == RA_MODE) begin
            mode_size <= reg_wdata[1:0];
            mode_wide <= reg_wdata[4];
        end
    end

    // Accumulators, code capture and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            par_q     <= '0;
            inv_q     <= '0;
            code_q    <= '0;
            err_any   <= 1'b0;
            err_code  <= 1'b0;
            err_multi <= 1'b0;
            done      <= 1'b0;
        end else if (data_step) begin
            par_q <= par_q ^ p_contrib;
            inv_q <= inv_q ^ n_contrib;
        end else if (code_step) begin
            code_q <= code_nx;
            if (code_last) begin
                par_q     <= syn_p;
                inv_q     <= syn_n;
                err_any   <= (cls != CL_NONE);
                err_code  <= (cls == CL_CODE);
                err_multi <= (cls == CL_MULTI);
                done      <= 1'b1;
            end
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_MODE: reg_rdata = {{(REG_W-5){1'b0}}, mode_wide, 2'b00, mode_size};
            RA_STAT: reg_rdata = {{(REG_W-4){1'b0}}, done, err_multi, err_code, err_any};
            RA_PAR:  reg_rdata = par_q;
            RA_INV:  reg_rdata = inv_q;
            default: reg_rdata = '0;
        endcase
    end

    // R8: a clear empties the results on the next cycle.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (par_q == '0 && inv_q == '0 && !done && !err_any));

    // R9: done follows the last code word by one cycle.
    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_last && !clr) |=> done);

    // R9: results are frozen once the check is complete.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> ($stable(par_q) && $stable(inv_q) && $stable(err_any)));

    // R2: cycles without bus_valid leave the accumulators alone.
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && !clr) |=> ($stable(par_q) && $stable(inv_q)));

    // R4: before done no flag is raised; after done, any-error matches a nonzero syndrome.
    p_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_any == (done && (par_q != '0 || inv_q != '0)));

    // R6: a code error leaves exactly one syndrome bit set.
    p_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code) |-> ($countones({inv_q, par_q}) == 1));

    // R5: a data error leaves complementary syndrome halves.
    p_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_any && !err_code && !err_multi) |-> (par_q == ~inv_q));
endmodule

// File: tb/sim_ecc_page_engine.sv
`timescale 1ns/1ps
module sim_ecc_page_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_data = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ecc_page_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_data(bus_data),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_valid = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_valid = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic bus_word(input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_data = d;
    endtask

    function automatic logic [15:0] pat(input int w, input int seed, input bit wide, input bit erased);
        logic [15:0] v;
        if (erased) return wide ? 16'hFFFF : 16'h00FF;
        v = 16'(w * 40503 + seed * 945 + (w >> 2) * 7 + 3);
        return wide ? v : {8'h00, v[7:0] ^ v[15:8]};
    endfunction

    // Expected code {inverse, parity} of a clean page, per R3.
    function automatic logic [31:0] gold(input int size, input bit wide, input int seed, input bit erased);
        logic [15:0] p = '0, n = '0, d, idx;
        int words = (512 << size) >> wide;
        int nb = wide ? 16 : 8;
        for (int w = 0; w < words; w++) begin
            d = pat(w, seed, wide, erased);
            for (int b = 0; b < nb; b++) begin
                if (d[b]) begin
                    idx = 16'((w << 4) | b);
                    p ^= idx; n ^= ~idx;
                end
            end
        end
        return {n, p};
    endfunction

    // Runs one page; flips up to two data bits and optionally one code bit.
    task automatic run_page(input int size, input bit wide, input int seed, input bit erased,
                            input int nflip, input int fw0, input int fb0, input int fw1, input int fb1,
                            input int cflip, input bit gap,
                            output logic [15:0] pre_p, output logic [15:0] pre_n,
                            output logic [15:0] st_mid, output logic [15:0] st,
                            output logic [15:0] sp, output logic [15:0] sn);
        int words = (512 << size) >> wide;
        logic [15:0] d;
        logic [31:0] code;
        reg_write(3'd1, 16'((int'(wide) << 4) | size));
        reg_write(3'd0, 16'h0001);
        for (int w = 0; w < words; w++) begin
            d = pat(w, seed, wide, erased);
            if (nflip > 0 && w == fw0) d[fb0] = ~d[fb0];
            if (nflip > 1 && w == fw1) d[fb1] = ~d[fb1];
            bus_word(d);
            if (gap) begin
                @(negedge clk);
                bus_valid = 1'b0; bus_data = ~d;
            end
        end
        reg_read(3'd3, pre_p);
        reg_read(3'd4, pre_n);
        code = erased ? 32'hFFFF_FFFF : gold(size, wide, seed, 1'b0);
        if (cflip >= 0) code[cflip] = ~code[cflip];
        if (wide) begin
            bus_word(code[15:0]);
            reg_read(3'd2, st_mid);
            bus_word(code[31:16]);
        end else begin
            bus_word({8'h00, code[7:0]});
            bus_word({8'h00, code[15:8]});
            bus_word({8'h00, code[23:16]});
            reg_read(3'd2, st_mid);
            bus_word({8'h00, code[31:24]});
        end
        reg_read(3'd2, st);
        reg_read(3'd3, sp);
        reg_read(3'd4, sn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, pp, pn, sm, st, sp, sn;
        logic [31:0] g;
        logic [15:0] idx, idx2;
        int wlist_w[6] = '{0, 1, 85, 170, 254, 255};
        int wlist_n[6] = '{0, 1, 170, 341, 510, 511};
        int clist[4] = '{0, 7, 8, 31};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        reg_read(3'd1, v); check("R11 mode", {16'h0, v}, 32'h0);
        reg_read(3'd2, v); check("R11 status", {16'h0, v}, 32'h0);
        reg_read(3'd3, v); check("R11 parity", {16'h0, v}, 32'h0);
        reg_read(3'd4, v); check("R11 inverse", {16'h0, v}, 32'h0);

        // R1 R3 R4 R2: clean pages at every size and width
        for (int s = 0; s < 4; s++) begin
            for (int wd = 0; wd < 2; wd++) begin
                g = gold(s, wd[0], s + 3 * wd, 1'b0);
                run_page(s, wd[0], s + 3 * wd, 1'b0, 0, 0, 0, 0, 0, -1, (s == 0), pp, pn, sm, st, sp, sn);
                check("R3 R1 parity after data", {16'h0, pp}, {16'h0, g[15:0]});
                check("R3 R1 inverse after data", {16'h0, pn}, {16'h0, g[31:16]});
                check("R9 not done before last code word", {16'h0, sm}, 32'h0);
                check("R4 R2 clean status", {16'h0, st}, 32'h8);
                check("R4 clean syndrome", {sn, sp}, 32'h0);
            end
        end

        // R5 R10: single data bit sweep, 16-bit bus
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 16; b++) begin
                run_page(0, 1'b1, i + b, 1'b0, 1, wlist_w[i], b, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
                idx = 16'((wlist_w[i] << 4) | b);
                check("R5 R10 wide data error status", {16'h0, st}, 32'h9);
                check("R5 R10 wide location", {sn, sp}, {~idx, idx});
            end
        end

        // R5 R10: single data bit sweep, 8-bit bus
        for (int i = 0; i < 6; i++) begin
            for (int b = 0; b < 8; b++) begin
                run_page(0, 1'b0, 2 * i + b, 1'b0, 1, wlist_n[i], b, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
                idx = 16'((wlist_n[i] << 4) | b);
                check("R5 R10 narrow data error status", {16'h0, st}, 32'h9);
                check("R5 R10 narrow location", {sn, sp}, {~idx, idx});
            end
        end

        // R5 R1: last word of the largest page in both widths
        run_page(3, 1'b0, 9, 1'b0, 1, 4095, 7, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
        check("R5 R1 narrow last word status", {16'h0, st}, 32'h9);
        check("R5 R1 narrow last word location", {sn, sp}, {16'h0008, 16'hFFF7});
        run_page(3, 1'b1, 4, 1'b0, 1, 2047, 15, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
        check("R5 R1 wide last word status", {16'h0, st}, 32'h9);
        check("R5 R1 wide last word location", {sn, sp}, {16'h8000, 16'h7FFF});

        // R6: every code bit flipped on a 16-bit bus
        for (int k = 0; k < 32; k++) begin
            run_page(0, 1'b1, k, 1'b0, 0, 0, 0, 0, 0, k, 1'b0, pp, pn, sm, st, sp, sn);
            check("R6 wide code error status", {16'h0, st}, 32'hB);
            check("R6 wide code syndrome", {sn, sp}, 32'h1 << k);
        end
        // R6 R3: code bits on an 8-bit bus, checking byte order
        for (int i = 0; i < 4; i++) begin
            run_page(0, 1'b0, 20 + i, 1'b0, 0, 0, 0, 0, 0, clist[i], 1'b0, pp, pn, sm, st, sp, sn);
            check("R6 R3 narrow code error status", {16'h0, st}, 32'hB);
            check("R6 R3 narrow code syndrome", {sn, sp}, 32'h1 << clist[i]);
        end

        // R7: two data flips
        run_page(0, 1'b1, 5, 1'b0, 2, 3, 2, 9, 5, -1, 1'b0, pp, pn, sm, st, sp, sn);
        idx = 16'((3 << 4) | 2); idx2 = 16'((9 << 4) | 5);
        check("R7 double error status", {16'h0, st}, 32'hD);
        check("R7 double error syndrome", {sn, sp}, {idx ^ idx2, idx ^ idx2});
        run_page(0, 1'b0, 6, 1'b0, 2, 100, 0, 100, 1, -1, 1'b0, pp, pn, sm, st, sp, sn);
        check("R7 same-word double error status", {16'h0, st}, 32'hD);
        // R7: erased pages
        run_page(0, 1'b0, 0, 1'b1, 0, 0, 0, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
        check("R7 erased narrow status", {16'h0, st}, 32'hD);
        check("R7 erased narrow address", {sn, sp}, 32'hFFFF_FFFF);
        run_page(1, 1'b1, 0, 1'b1, 0, 0, 0, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
        check("R7 erased wide status", {16'h0, st}, 32'hD);
        check("R7 erased wide address", {sn, sp}, 32'hFFFF_FFFF);

        // R9: data after done changes nothing
        run_page(0, 1'b1, 2, 1'b0, 1, 7, 3, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
        for (int i = 0; i < 20; i++) bus_word(16'(i * 4111 + 1));
        reg_read(3'd2, v); check("R9 status held after done", {16'h0, v}, 32'h9);
        reg_read(3'd3, v); check("R9 parity held after done", {16'h0, v}, 32'h0073);

        // R8: clear after done, then clear mid-page
        reg_write(3'd0, 16'h0001);
        reg_read(3'd2, v); check("R8 status cleared", {16'h0, v}, 32'h0);
        reg_read(3'd3, v); check("R8 parity cleared", {16'h0, v}, 32'h0);
        for (int w = 0; w < 100; w++) bus_word(pat(w, 1, 1'b1, 1'b0));
        reg_write(3'd0, 16'h0001);
        reg_read(3'd3, v); check("R8 mid-page parity cleared", {16'h0, v}, 32'h0);
        reg_read(3'd4, v); check("R8 mid-page inverse cleared", {16'h0, v}, 32'h0);
        run_page(0, 1'b1, 11, 1'b0, 0, 0, 0, 0, 0, -1, 1'b0, pp, pn, sm, st, sp, sn);
        check("R8 clean page after clear", {16'h0, st}, 32'h8);
        reg_read(3'd1, v); check("R10 mode readback", {16'h0, v}, 32'h10);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule